// File: doc/BRIEF.md
# Graphics DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank synchronous graphics DRAM. It takes the device from power-on to an idle, programmed state. When reset is released it holds the command bus at no-operation while a fixed start-up pause runs. The pause is 200 microseconds by default and is turned into a clock count from a clock-period parameter. During the pause the clock enable and the byte masks stay high.

After the pause the sequencer issues a precharge of every bank and then waits a precharge recovery time. Next it programs the mode register with the word on its `mode_word` input and waits the mode-set recovery time. It then issues a run of auto refresh commands, each followed by a row-cycle wait. Finally it raises `done` and keeps the bus at no-operation until the next reset.

All command, address and done outputs come straight from flip-flops. The command pins therefore change one clock edge after the internal state moves. Let P be the pause in cycles and sample index 0 be the cycle in which reset is released. The precharge then appears at index P.

Top module: `sgram_init_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are: the command is NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, dsf=0), `addr` is zero, `done` is 0, and `cke` and every `dqm` bit are 1.
- R2: After reset is released, samples 0 to P-1 show NOP with `addr` zero. P = ceil(PAUSE_NS / CLK_PERIOD_NS).
- R3: Sample P is a precharge (cs_n=0, ras_n=0, cas_n=1, we_n=0, dsf=0). In that sample `addr` has only bit AP_BIT set, which selects all banks.
- R4: The precharge is followed by exactly TRP_CYC NOP samples. The next sample is a mode register set, with all five command pins low and `addr` equal to `mode_word`.
- R5: The mode register set is followed by exactly TRSC_CYC NOP samples before the next command.
- R6: Exactly N_REF auto refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1, dsf=0) are issued, with `addr` zero. Each one is followed by exactly TRC_CYC NOP samples.
- R7: `done` rises in the sample right after the last refresh wait. It then stays 1, with the command at NOP, until reset.
- R8: `cke` and all `dqm` bits stay 1 from reset through the end of the sequence. This includes the cycles before the mode register set.
- R9: A reset asserted at any point of the sequence restarts it from the beginning of the pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | ADDR_W | Value written into the mode register; must be held stable through the sequence |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dsf | output | 1 | Special-function select, low for every command issued here |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Byte masks, held high |
| addr | output | ADDR_W | Address bus: all-banks bit during precharge, mode word during mode set |
| done | output | 1 | Initialization complete, sticky until reset |

## Verification
A wrong state or counter value in this block appears on the command pins within one clock edge. The symptom is a command that comes too early or too late, or a missing or extra refresh. The bench therefore compares every sample after reset release against a cycle-indexed model of the whole sequence. It also compares `addr` at the precharge and at the mode set, so a wrong address shows up as well. A refresh counter that is off by one shows up as a shifted `done` edge, about one row-cycle (TRC_CYC+1 samples) too early or too late. Resets cut in at random indices check that no state survives a restart.

// File: rtl/sgram_init_seq.sv
module sgram_init_seq #(
  parameter int CLK_PERIOD_NS = 5,
  parameter int PAUSE_NS      = 200000,
  parameter int TRP_CYC       = 3,
  parameter int TRSC_CYC      = 2,
  parameter int TRC_CYC       = 9,
  parameter int N_REF         = 8,
  parameter int ADDR_W        = 11,
  parameter int AP_BIT        = 10,
  parameter int DQM_W         = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              dsf,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam int PAUSE_CYC = (PAUSE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int M1   = (TRP_CYC > TRSC_CYC) ? TRP_CYC : TRSC_CYC;
  localparam int M2   = (M1 > TRC_CYC) ? M1 : TRC_CYC;
  localparam int MAXC = (PAUSE_CYC > M2) ? PAUSE_CYC : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = $clog2(N_REF + 1);

  localparam logic [4:0] C_NOP = 5'b01110;
  localparam logic [4:0] C_PRE = 5'b00100;
  localparam logic [4:0] C_MRS = 5'b00000;
  localparam logic [4:0] C_REF = 5'b00010;

  typedef enum logic [2:0] {S_PAUSE, S_PRE, S_TRP, S_MRS, S_TRSC, S_REF, S_TRC, S_DONE} st_t;

  st_t             st, st_n;
  logic [CW-1:0]   cnt, lim;
  logic [RW-1:0]   refs;
  logic [4:0]      cmd_q, cmd_n;
  logic [ADDR_W-1:0] addr_n;
  logic            expired;

  always_comb begin
    case (st)
      S_PAUSE: lim = CW'(PAUSE_CYC);
      S_TRP:   lim = CW'(TRP_CYC);
      S_TRSC:  lim = CW'(TRSC_CYC);
      S_TRC:   lim = CW'(TRC_CYC);
      default: lim = CW'(1);
    endcase
  end

  assign expired = (cnt == lim - CW'(1));

  always_comb begin
    st_n = st;
    case (st)
      S_PAUSE: if (expired) st_n = S_PRE;
      S_PRE:   st_n = S_TRP;
      S_TRP:   if (expired) st_n = S_MRS;
      S_MRS:   st_n = S_TRSC;
      S_TRSC:  if (expired) st_n = S_REF;
      S_REF:   st_n = S_TRC;
      S_TRC:   if (expired) st_n = (refs == RW'(N_REF)) ? S_DONE : S_REF;
      default: st_n = S_DONE;
    endcase
  end

  always_comb begin
    case (st_n)
      S_PRE:   cmd_n = C_PRE;
      S_MRS:   cmd_n = C_MRS;
      S_REF:   cmd_n = C_REF;
      default: cmd_n = C_NOP;
    endcase
    addr_n = '0;
    if (st_n == S_PRE) addr_n[AP_BIT] = 1'b1;
    if (st_n == S_MRS) addr_n = mode_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_PAUSE;
      cnt   <= '0;
      refs  <= '0;
      cmd_q <= C_NOP;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      st    <= st_n;
      if (st_n != st)       cnt <= '0;
      else if (st != S_DONE) cnt <= cnt + CW'(1);
      if (st == S_REF)      refs <= refs + RW'(1);
      cmd_q <= cmd_n;
      addr  <= addr_n;
      done  <= (st_n == S_DONE);
    end
  end

  assign {cs_n, ras_n, cas_n, we_n, dsf} = cmd_q;
  assign cke = 1'b1;
  assign dqm = '1;

  p_pre_then_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_PRE) |=> (cmd_q == C_NOP));
  p_mrs_after_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_MRS) |-> ($past(cmd_q) == C_NOP));
  p_mrs_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_MRS) |-> (addr == $past(mode_word)));
  p_ref_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (refs <= RW'(N_REF)));
  p_ref_then_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF) |=> (cmd_q == C_NOP));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_q == C_NOP && addr == '0));
endmodule

// File: tb/sim_sgram_init_seq.sv
`timescale 1ns/1ps
module sim_sgram_init_seq;
  localparam int CLK_NS = 5;
  localparam int PNS    = 400;
  localparam int TRP    = 3;
  localparam int TRSC   = 2;
  localparam int TRC    = 7;
  localparam int NREF   = 8;
  localparam int AW     = 11;
  localparam int APB    = 10;
  localparam int DW     = 4;
  localparam int P      = (PNS + CLK_NS - 1) / CLK_NS;
  localparam int IM     = P + TRP + 1;
  localparam int IR0    = IM + TRSC + 1;
  localparam int ID     = IR0 + NREF * (1 + TRC);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] mode_word = '0;
  logic cs_n, ras_n, cas_n, we_n, dsf, cke, done;
  logic [DW-1:0] dqm;
  logic [AW-1:0] addr;
  int checks = 0, fails = 0, refs_seen;

  always #2.5 clk = ~clk;

  sgram_init_seq #(.CLK_PERIOD_NS(CLK_NS), .PAUSE_NS(PNS), .TRP_CYC(TRP), .TRSC_CYC(TRSC),
    .TRC_CYC(TRC), .N_REF(NREF), .ADDR_W(AW), .AP_BIT(APB), .DQM_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .dsf(dsf), .cke(cke), .dqm(dqm), .addr(addr), .done(done));

  function automatic logic [4:0] exp_cmd(int i);
    if (i == P) return 5'b00100;
    if (i == IM) return 5'b00000;
    if (i >= IR0 && i < ID && ((i - IR0) % (1 + TRC)) == 0) return 5'b00010;
    return 5'b01110;
  endfunction

  function automatic logic [AW-1:0] exp_addr(int i, logic [AW-1:0] mw);
    logic [AW-1:0] a = '0;
    if (i == P) a[APB] = 1'b1;
    if (i == IM) a = mw;
    return a;
  endfunction

  function automatic string tag(int i);
    if (i < P) return "R2";
    if (i == P) return "R3";
    if (i <= IM) return "R4";
    if (i < IR0) return "R5";
    if (i < ID) return "R6";
    return "R7";
  endfunction

  task automatic chk(string rq, logic [24:0] act, logic [24:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, expv, $time);
    end
  endtask

  function automatic logic [24:0] pins();
    return {7'd0, done, cke, dqm, addr, cs_n, ras_n, cas_n, we_n, dsf} >> 0;
  endfunction

  task automatic run(int stop_at, logic [AW-1:0] mw);
    @(negedge clk);
    rst_n = 1'b0;
    mode_word = mw;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1", pins(), {7'd0, 1'b0, 1'b1, {DW{1'b1}}, {AW{1'b0}}, 5'b01110});
    end
    rst_n = 1'b1;
    refs_seen = 0;
    for (int i = 0; i <= stop_at; i++) begin
      if (i > 0) @(negedge clk);
      if ({cs_n, ras_n, cas_n, we_n, dsf} == 5'b00010) refs_seen++;
      chk(tag(i), pins(), {7'd0, (i >= ID), 1'b1, {DW{1'b1}}, exp_addr(i, mw), exp_cmd(i)});
      if (i < IM) chk("R8", {24'd0, cke & (&dqm)}, 25'd1);
    end
    if (stop_at >= ID) chk("R6", 25'(refs_seen), 25'(NREF));
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", wd);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    run(ID + 12, {AW{1'b1}});
    run(ID + 12, '0);
    for (int r = 0; r < 6; r++) begin
      // R9: cut the sequence at a random point, next run must restart cleanly
      run($urandom_range(ID + 5, 0), AW'($urandom));
      run(ID + 20, AW'($urandom));
    end
    run(P, 11'h2A5);
    run(IR0 + 3, 11'h155);
    run(ID + 40, 11'h7F0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule